// File: doc/BRIEF.md
# Programmable Critical Interrupt Prioritizer

The block arbitrates between four critical interrupt sources: an external request pin (source 0), a timer event (source 1), a steerable high-urgency peripheral slot (source 2) and a wakeup event (source 3). Every request is caught in a sticky pending bit. Among the pending sources that are allowed to interrupt, the one whose 2-bit programmed priority is largest wins. Equal priorities fall back to index order, with the lower index first. The winner's index is presented on an output, together with a request on either the dedicated critical interrupt line or the normal interrupt line.

Software reaches the block through a simple word-wide register port with three registers. The priority register holds the four priority fields and a mask field that is only stored. The control register holds the enable for the external pin and a redirect bit, which moves critical requests onto the normal interrupt line for a single-handler scheme. The status register shows the pending bits and clears them by write-one-to-clear. The pending bits are visible whether or not the source is allowed to interrupt, so software reads critical status before it looks at normal status.

Top module: `crit_prio_top`

## Requirements
- R1: After reset, all three registers read zero, `crit_irq_o` and `norm_irq_o` are low and `win_idx_o` is 0.
- R2: Address 0 is the priority register. Bits [31:30] set the priority of source 0, [29:28] source 1, [27:26] source 2 and [25:24] source 3. Bits [16:0] form a stored mask field. Bits [23:17] read as zero and ignore writes.
- R3: Among the eligible pending sources, the one with the numerically larger priority value is selected, so 3 is the most urgent.
- R4: Among eligible pending sources with equal priority, the lower-numbered source is selected. With all priorities zero, the order is 0, 1, 2, 3.
- R5: Address 2 bits [3:0] are the pending bits of sources 0 to 3. A request sets its bit whether or not the source is enabled. Writing 1 to a bit clears it. A request in the same cycle as a clear leaves the bit set.
- R6: Address 1 bit 0 enables source 0. While it is 0, a pending source 0 never selects or raises an interrupt. Sources 1 to 3 are always eligible.
- R7: Address 1 bit 1 is the redirect bit. When it is 0, `crit_irq_o` is raised for a winner and `norm_irq_o` stays low. When it is 1, `norm_irq_o` is raised instead and `crit_irq_o` stays low.
- R8: The outputs follow the register state with one clock of latency. A request sampled at edge k shows on the outputs after edge k+1. When nothing is eligible, both interrupt lines are low and `win_idx_o` is 0.
- R9: Address 1 bits [31:2] and the whole of address 3 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| src_req_i | input | 4 | Critical source requests, bit i is source i |
| win_idx_o | output | 2 | Index of the selected source |
| crit_irq_o | output | 1 | Critical interrupt request |
| norm_irq_o | output | 1 | Critical request routed to the normal line |

## Verification
Read data is combinational. The bench samples it 1 ns after it drives the inputs at the falling edge, and compares it with the register contents from before the next rising edge. A write or a request takes effect in the register state at the rising edge. The selected index and the interrupt lines show that state one edge later. The bench model therefore computes its expected outputs from its state before each rising-edge update, and compares them at the following falling edge. This places every output check exactly one register stage behind the state that caused it.

// File: rtl/crit_prio_pkg.sv
package crit_prio_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned NUM_SRC    = 4;
  localparam int unsigned PRIO_W     = 2;
  localparam int unsigned MASK_W     = 17;
  localparam logic [1:0]  ADDR_PRIO  = 2'd0;
  localparam logic [1:0]  ADDR_CTL   = 2'd1;
  localparam logic [1:0]  ADDR_STAT  = 2'd2;
endpackage

// File: rtl/crit_prio_regs.sv
module crit_prio_regs
  import crit_prio_pkg::*;
#(
  parameter int unsigned N_SRC = NUM_SRC,
  parameter int unsigned P_W   = PRIO_W,
  parameter int unsigned M_W   = MASK_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [1:0]           addr_i,
  input  logic [REG_W-1:0]     wdata_i,
  output logic [REG_W-1:0]     rdata_o,
  input  logic [N_SRC-1:0]     req_i,
  output logic [N_SRC*P_W-1:0] prio_o,
  output logic [N_SRC-1:0]     elig_o,
  output logic                 redir_o
);
  localparam int unsigned PF_W  = N_SRC * P_W;
  localparam int unsigned RSV_W = REG_W - PF_W - M_W;

  logic [PF_W-1:0]  prio_word_q;
  logic [M_W-1:0]   mask_q;
  logic             ext_en_q, redir_q;
  logic [N_SRC-1:0] pend_q, clr_v;

  logic wr_prio, wr_ctl, wr_stat;
  assign wr_prio = we_i && (addr_i == ADDR_PRIO);
  assign wr_ctl  = we_i && (addr_i == ADDR_CTL);
  assign wr_stat = we_i && (addr_i == ADDR_STAT);
  assign clr_v   = wr_stat ? wdata_i[N_SRC-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_word_q <= '0;
      mask_q      <= '0;
      ext_en_q    <= 1'b0;
      redir_q     <= 1'b0;
      pend_q      <= '0;
    end else begin
      if (wr_prio) begin
        prio_word_q <= wdata_i[REG_W-1 -: PF_W];
        mask_q      <= wdata_i[M_W-1:0];
      end
      if (wr_ctl) begin
        ext_en_q <= wdata_i[0];
        redir_q  <= wdata_i[1];
      end
      // set wins over clear
      pend_q <= (pend_q & ~clr_v) | req_i;
    end
  end

  // word order is msb-first: source 0 occupies the top field
  for (genvar i = 0; i < N_SRC; i++) begin : g_prio_map
    assign prio_o[i*P_W +: P_W] = prio_word_q[PF_W-1-i*P_W -: P_W];
  end

  assign elig_o  = pend_q & {{(N_SRC-1){1'b1}}, ext_en_q};
  assign redir_o = redir_q;

  always_comb begin
    unique case (addr_i)
      ADDR_PRIO: rdata_o = {prio_word_q, {RSV_W{1'b0}}, mask_q};
      ADDR_CTL:  rdata_o = {{(REG_W-2){1'b0}}, redir_q, ext_en_q};
      ADDR_STAT: rdata_o = {{(REG_W-N_SRC){1'b0}}, pend_q};
      default:   rdata_o = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata_i[REG_W-PF_W-1:M_W];

  p_sticky_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(req_i) & ~pend_q) == '0));

  p_w1c_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(clr_v & ~req_i) & pend_q) == '0));
endmodule

// File: rtl/crit_prio_arb.sv
module crit_prio_arb
  import crit_prio_pkg::*;
#(
  parameter int unsigned N_SRC = NUM_SRC,
  parameter int unsigned P_W   = PRIO_W,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]     elig_i,
  input  logic [N_SRC*P_W-1:0] prio_i,
  output logic                 vld_o,
  output logic [IDX_W-1:0]     idx_o
);
  logic [P_W-1:0] best;

  // strict compare keeps the lower index on equal priority
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    best  = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig_i[i] && (!vld_o || (prio_i[i*P_W +: P_W] > best))) begin
        vld_o = 1'b1;
        idx_o = IDX_W'(i);
        best  = prio_i[i*P_W +: P_W];
      end
    end
  end
endmodule

// File: rtl/crit_prio_out.sv
module crit_prio_out
  import crit_prio_pkg::*;
#(
  parameter int unsigned N_SRC = NUM_SRC,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             redir_i,
  input  logic [N_SRC-1:0] elig_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             crit_o,
  output logic             norm_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o  <= '0;
      crit_o <= 1'b0;
      norm_o <= 1'b0;
    end else begin
      idx_o  <= idx_i;
      crit_o <= vld_i && !redir_i;
      norm_o <= vld_i && redir_i;
    end
  end

  p_winner_eligible_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crit_o || norm_o) |-> ((($past(elig_i) >> idx_o) & N_SRC'(1)) != '0));

  p_quiet_when_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elig_i == '0) |=> (!crit_o && !norm_o && idx_o == '0));

  p_route_crit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crit_o |-> !$past(redir_i));

  p_route_norm_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    norm_o |-> $past(redir_i));
endmodule

// File: rtl/crit_prio_top.sv
module crit_prio_top
  import crit_prio_pkg::*;
#(
  parameter int unsigned N_SRC = NUM_SRC,
  parameter int unsigned P_W   = PRIO_W,
  parameter int unsigned M_W   = MASK_W,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic [N_SRC-1:0] src_req_i,
  output logic [IDX_W-1:0] win_idx_o,
  output logic             crit_irq_o,
  output logic             norm_irq_o
);
  logic [N_SRC*P_W-1:0] prio;
  logic [N_SRC-1:0]     elig;
  logic                 redir, arb_vld;
  logic [IDX_W-1:0]     arb_idx;

  crit_prio_regs #(.N_SRC(N_SRC), .P_W(P_W), .M_W(M_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .req_i   (src_req_i),
    .prio_o  (prio),
    .elig_o  (elig),
    .redir_o (redir)
  );

  crit_prio_arb #(.N_SRC(N_SRC), .P_W(P_W)) u_arb (
    .elig_i (elig),
    .prio_i (prio),
    .vld_o  (arb_vld),
    .idx_o  (arb_idx)
  );

  crit_prio_out #(.N_SRC(N_SRC)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (arb_vld),
    .idx_i   (arb_idx),
    .redir_i (redir),
    .elig_i  (elig),
    .idx_o   (win_idx_o),
    .crit_o  (crit_irq_o),
    .norm_o  (norm_irq_o)
  );
endmodule

// File: tb/crit_prio_top_tb.sv
module crit_prio_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  req = '0;
  logic [1:0]  win_idx;
  logic        crit, norm;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // bench model state
  logic [7:0]  m_prio = '0;
  logic [16:0] m_mask = '0;
  logic        m_en = 1'b0, m_redir = 1'b0;
  logic [3:0]  m_pend = '0;
  logic        e_crit = 1'b0, e_norm = 1'b0;
  logic [1:0]  e_idx = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crit_prio_top u_dut (
    .clk_i (clk), .rst_ni (rst_n), .reg_we_i (we), .reg_addr_i (addr),
    .reg_wdata_i (wdata), .reg_rdata_o (rdata), .src_req_i (req),
    .win_idx_o (win_idx), .crit_irq_o (crit), .norm_irq_o (norm)
  );

  function automatic logic [31:0] model_read(input logic [1:0] a);
    case (a)
      2'd0:    return {m_prio, 7'b0, m_mask};
      2'd1:    return {30'b0, m_redir, m_en};
      2'd2:    return {28'b0, m_pend};
      default: return 32'b0;
    endcase
  endfunction

  // priority field of source s sits msb-first in bits [31-2s -: 2]
  function automatic void model_arb(output logic v, output logic [1:0] ix);
    logic [3:0] el;
    logic [1:0] best;
    el = m_pend & {3'b111, m_en};
    v = 1'b0; ix = 2'd0; best = 2'd0;
    for (int s = 0; s < 4; s++) begin
      if (el[s] && (!v || m_prio[7-2*s -: 2] > best)) begin
        v = 1'b1; ix = 2'(s); best = m_prio[7-2*s -: 2];
      end
    end
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] r, input logic w, input logic [1:0] a,
                      input logic [31:0] d, input string tag);
    logic v;
    logic [1:0] ix;
    @(negedge clk);
    check(tag, "outputs {crit,norm,idx}", {28'b0, crit, norm, win_idx},
          {28'b0, e_crit, e_norm, e_idx});
    req = r; we = w; addr = a; wdata = d;
    #1;
    check(tag, "rdata", rdata, model_read(a));
    @(posedge clk);
    model_arb(v, ix);
    e_crit = v && !m_redir;
    e_norm = v && m_redir;
    e_idx  = ix;
    if (w && a == 2'd0) begin m_prio = d[31:24]; m_mask = d[16:0]; end
    if (w && a == 2'd1) begin m_en = d[0]; m_redir = d[1]; end
    m_pend = (m_pend & ~((w && a == 2'd2) ? d[3:0] : 4'b0)) | r;
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) step(4'b0, 1'b0, 2'd2, 32'b0, tag);
  endtask

  initial begin
    repeat (CLK_PERIOD * 200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    step(4'b0, 1'b0, 2'd0, 32'b0, "R1");
    step(4'b0, 1'b0, 2'd1, 32'b0, "R1");
    step(4'b0, 1'b0, 2'd2, 32'b0, "R1");
    // R2 layout and reserved bits
    step(4'b0, 1'b1, 2'd0, 32'hFFFF_FFFF, "R2");
    step(4'b0, 1'b0, 2'd0, 32'b0, "R2");
    check("R2", "reserved read", rdata, 32'hFF01_FFFF);
    // R9 control upper bits and unused address
    step(4'b0, 1'b1, 2'd1, 32'hFFFF_FFFC, "R9");
    step(4'b0, 1'b0, 2'd1, 32'b0, "R9");
    step(4'b0, 1'b0, 2'd3, 32'b0, "R9");
    // R4 ties: all priorities zero, source 0 enabled
    step(4'b0, 1'b1, 2'd0, 32'h0000_0000, "R4");
    step(4'b0, 1'b1, 2'd1, 32'h1, "R4");
    step(4'b0110, 1'b0, 2'd2, 32'b0, "R4");
    idle(2, "R4");
    check("R4", "tie winner", {30'b0, win_idx}, 32'd1);
    step(4'b1111, 1'b0, 2'd2, 32'b0, "R4");
    idle(2, "R4");
    check("R4", "default order", {30'b0, win_idx}, 32'd0);
    // R3 larger value wins: source 3 = 3, source 2 = 2
    step(4'b0, 1'b1, 2'd0, 32'h0B00_0000, "R3");
    idle(2, "R3");
    check("R3", "highest value", {30'b0, win_idx}, 32'd3);
    // R8 cleared: nothing eligible gives quiet outputs
    step(4'b0, 1'b1, 2'd2, 32'hF, "R8");
    idle(2, "R8");
    check("R8", "idle outputs", {29'b0, crit, norm, |win_idx}, 32'd0);
    // R6 source 0 gated by enable, still pending
    step(4'b0, 1'b1, 2'd1, 32'h0, "R6");
    step(4'b0001, 1'b0, 2'd2, 32'b0, "R6");
    idle(2, "R6");
    check("R6", "gated src0 quiet", {30'b0, crit, norm}, 32'd0);
    check("R5", "pending while disabled", rdata, 32'h1);
    // R7 redirect
    step(4'b0, 1'b1, 2'd1, 32'h3, "R7");
    idle(2, "R7");
    check("R7", "redirected", {30'b0, crit, norm}, 32'b01);
    step(4'b0, 1'b1, 2'd1, 32'h1, "R7");
    // R5 set wins over clear
    step(4'b0001, 1'b1, 2'd2, 32'h1, "R5");
    idle(1, "R5");
    check("R5", "set over clear", rdata, 32'h1);
    step(4'b0, 1'b1, 2'd2, 32'hF, "R5");
    idle(1, "R5");
    check("R5", "w1c", rdata, 32'h0);
    // random mix, all fields checked against model (R3 R4 R5 R6 R7 R8)
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] r;
      logic w;
      r = 4'($urandom) & 4'($urandom) & 4'($urandom);
      w = ($urandom % 4) == 0;
      step(r, w, 2'($urandom), $urandom, "R3");
    end
    idle(2, "R8");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule